// File: doc/BRIEF.md
# Reference-Pulse Oscillator Period Calibrator

This block sits in the oscillator clock domain of a low-power sensor. A free-running, drift-prone oscillator clocks it. Now and then an external reader supplies a reference pulse. The block counts how many oscillator cycles the pulse stays high and keeps that count as the calibrated width. From the stored width it then regenerates a steady sampling clock. A second counter runs against the stored width, and a comparator raises a single-cycle match strobe each time the counter reaches the width. The match strobes toggle a divide-by-two stage, so the sampling clock period is twice the digitized pulse width.

Each later reference pulse measures the width again and replaces the stored value, which corrects any drift of the oscillator. A pulse that is too long for the counter is rejected: the previous width is kept and an overflow flag is raised. Until the first pulse has been accepted after reset, the sampling clock and the match strobe stay low and the valid flag stays clear. A 2-bit coarse trim code passes straight through to the oscillator. The reference pulse is asynchronous, and a flop chain brings it into the oscillator domain before its edges are detected.

Top module: `osc_period_calibrator`

## Requirements
- R1: `trim_out` equals `trim_in` at all times, for all four codes 0 to 3, independent of reset and calibration state.
- R2: While `rst_n` is low, and directly after it rises, `match_pulse`, `samp_clk`, `cal_valid` and `cal_overflow` are all 0.
- R3: A reference pulse that is sampled high on N consecutive rising oscillator edges, with 1 <= N <= 4094, is accepted. The stored width D becomes N, `cal_valid` becomes 1 and `cal_overflow` becomes 0.
- R4: Once calibrated, `match_pulse` is high for exactly one cycle in every D cycles, so every window of 2D consecutive cycles holds exactly two high cycles. When D = 1 it stays high.
- R5: `samp_clk` toggles once per match strobe. It is high for D cycles and low for D cycles, which gives a period of 2D cycles.
- R6: Before the first accepted pulse after reset, `samp_clk`, `match_pulse` and `cal_valid` stay 0. Once set, `cal_valid` stays 1 until reset.
- R7: A pulse sampled high on 4095 or more edges saturates the width counter and is rejected. `cal_overflow` becomes 1, the stored width is kept and `samp_clk` keeps its previous period. The next accepted pulse clears `cal_overflow`.
- R8: An accepted pulse with width N replaces the previous width. The sampling clock restarts low and then runs with period 2N.
- R9: While a new reference pulse is being measured, `samp_clk` keeps running with the period set by the previous width.
- R10: The reference pulse passes through two synchronizing flops. After reset, with `ref_pulse` lowered between edge N and edge N+1 of the pulse, `samp_clk` is first seen high after the (D+3)-th rising edge that follows the lowering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock; all logic runs on its rising edge |
| rst_n | input | 1 | Active-low reset, synchronous to clk_osc |
| ref_pulse | input | 1 | Asynchronous reference pulse from the external reader |
| trim_in | input | 2 | Coarse oscillator trim code |
| trim_out | output | 2 | Trim code passed through to the oscillator |
| match_pulse | output | 1 | One-cycle strobe each time the period counter reaches the stored width |
| samp_clk | output | 1 | Regenerated sampling clock, period twice the stored width |
| cal_valid | output | 1 | Set after the first accepted calibration |
| cal_overflow | output | 1 | Set when the last pulse was too long and was rejected |

## Verification
The assertions assume that `ref_pulse` changes only at low rate compared with the oscillator: each high or low phase lasts several oscillator cycles, so the synchronizer never sees a rise and a fall back to back. The stimulus meets this by changing `ref_pulse` only on falling oscillator edges, holding it high for whole numbers of cycles and keeping it low for at least several cycles between pulses. The assertions also assume that reset is applied before any pulse. The bench resets the block before each sweep point, so every latency figure is counted from a known idle state.

// File: rtl/osc_cal_pkg.sv
package osc_cal_pkg;

  localparam int DEF_CNT_W       = 12;
  localparam int DEF_SYNC_STAGES = 2;

  // Edge events of the synchronized reference pulse
  typedef struct packed {
    logic level;
    logic rise;
    logic fall;
  } ref_evt_t;

  typedef enum logic {
    MEAS_IDLE = 1'b0,
    MEAS_RUN  = 1'b1
  } meas_state_t;

endpackage

// File: rtl/ref_edge_sync.sv
module ref_edge_sync
  import osc_cal_pkg::*;
#(
  parameter int STAGES = DEF_SYNC_STAGES
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ref_async,
  output ref_evt_t evt
);

  logic [STAGES:0] chain;
  logic            level_prev;

  assign chain[0] = ref_async;

  for (genvar g = 0; g < STAGES; g++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rst_n) chain[g+1] <= 1'b0;
      else        chain[g+1] <= chain[g];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) level_prev <= 1'b0;
    else        level_prev <= chain[STAGES];
  end

  assign evt.level = chain[STAGES];
  assign evt.rise  = chain[STAGES] & ~level_prev;
  assign evt.fall  = ~chain[STAGES] & level_prev;

  // R10: a detected rise is followed by the level staying high next cycle
  assert_rise_follows_chain_R10: assert property (@(posedge clk) disable iff (!rst_n)
    evt.rise |=> level_prev);

endmodule

// File: rtl/width_capture.sv
module width_capture
  import osc_cal_pkg::*;
#(
  parameter int CNT_W = DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ref_evt_t         evt,
  output logic [CNT_W-1:0] width_q,
  output logic             valid_q,
  output logic             ovf_q,
  output logic             load_evt,
  output logic             reject_evt
);

  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  meas_state_t      state;
  logic [CNT_W-1:0] run_cnt;

  function automatic logic is_full(input logic [CNT_W-1:0] c);
    return c == {CNT_W{1'b1}};
  endfunction

  function automatic logic is_zero(input logic [CNT_W-1:0] c);
    return c == '0;
  endfunction

  // Accepted when the pulse ends below saturation
  assign load_evt   = evt.fall && (state == MEAS_RUN) && !is_full(run_cnt) && !is_zero(run_cnt);
  assign reject_evt = evt.fall && (state == MEAS_RUN) && is_full(run_cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= MEAS_IDLE;
      run_cnt <= '0;
    end else if (evt.rise) begin
      state   <= MEAS_RUN;
      run_cnt <= CNT_ONE;
    end else if (evt.fall) begin
      state   <= MEAS_IDLE;
      run_cnt <= '0;
    end else if (evt.level && state == MEAS_RUN && !is_full(run_cnt)) begin
      run_cnt <= run_cnt + CNT_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      width_q <= '0;
      valid_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else if (load_evt) begin
      width_q <= run_cnt;
      valid_q <= 1'b1;
      ovf_q   <= 1'b0;
    end else if (reject_evt) begin
      ovf_q   <= 1'b1;
    end
  end

  assert_hold_kept_on_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reject_evt |=> ($stable(width_q) && ovf_q));

  assert_width_from_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (width_q == $past(run_cnt) && valid_q && !ovf_q));

  assert_valid_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(valid_q));

  assert_nonzero_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> !is_zero(width_q));

endmodule

// File: rtl/period_regen.sv
module period_regen
  import osc_cal_pkg::*;
#(
  parameter int CNT_W = DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] width,
  input  logic             valid,
  input  logic             load,
  output logic             match,
  output logic             samp_clk
);

  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] per_cnt;
  logic             samp_q;

  function automatic logic at_last(input logic [CNT_W-1:0] c,
                                   input logic [CNT_W-1:0] w);
    return c == (w - CNT_ONE);
  endfunction

  assign match    = valid && at_last(per_cnt, width);
  assign samp_clk = samp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_cnt <= '0;
      samp_q  <= 1'b0;
    end else if (load) begin
      per_cnt <= '0;
      samp_q  <= 1'b0;
    end else if (valid) begin
      if (match) begin
        per_cnt <= '0;
        samp_q  <= ~samp_q;
      end else begin
        per_cnt <= per_cnt + CNT_ONE;
      end
    end
  end

  assert_match_needs_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> valid);

  assert_clock_idle_uncal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> !samp_clk);

  assert_toggle_on_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(samp_clk) |-> $past(match || load));

  assert_counter_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (per_cnt < width));

  assert_match_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (match && !load && width != CNT_ONE) |=> !match);

endmodule

// File: rtl/osc_period_calibrator.sv
module osc_period_calibrator
  import osc_cal_pkg::*;
#(
  parameter int CNT_W       = DEF_CNT_W,
  parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic       clk_osc,
  input  logic       rst_n,
  input  logic       ref_pulse,
  input  logic [1:0] trim_in,
  output logic [1:0] trim_out,
  output logic       match_pulse,
  output logic       samp_clk,
  output logic       cal_valid,
  output logic       cal_overflow
);

  ref_evt_t         ref_evt;
  logic [CNT_W-1:0] stored_width;
  logic             load_evt;
  logic             reject_evt;

  assign trim_out = trim_in;

  ref_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk_osc),
    .rst_n     (rst_n),
    .ref_async (ref_pulse),
    .evt       (ref_evt)
  );

  width_capture #(.CNT_W(CNT_W)) u_capture (
    .clk        (clk_osc),
    .rst_n      (rst_n),
    .evt        (ref_evt),
    .width_q    (stored_width),
    .valid_q    (cal_valid),
    .ovf_q      (cal_overflow),
    .load_evt   (load_evt),
    .reject_evt (reject_evt)
  );

  period_regen #(.CNT_W(CNT_W)) u_regen (
    .clk      (clk_osc),
    .rst_n    (rst_n),
    .width    (stored_width),
    .valid    (cal_valid),
    .load     (load_evt),
    .match    (match_pulse),
    .samp_clk (samp_clk)
  );

  assert_trim_passthrough_R1: assert property (@(posedge clk_osc)
    trim_out == trim_in);

  assert_accept_reject_exclusive_R7: assert property (@(posedge clk_osc) disable iff (!rst_n)
    !(load_evt && reject_evt));

endmodule

// File: tb/test_osc_period_calibrator.sv
module test_osc_period_calibrator;

  logic       clk_osc = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_pulse = 1'b0;
  logic [1:0] trim_in = 2'd0;
  logic [1:0] trim_out;
  logic       match_pulse, samp_clk, cal_valid, cal_overflow;

  int errors = 0;
  int checks = 0;

  always #10 clk_osc = ~clk_osc;   // 50 MHz

  osc_period_calibrator i_osc_period_calibrator (
    .clk_osc      (clk_osc),
    .rst_n        (rst_n),
    .ref_pulse    (ref_pulse),
    .trim_in      (trim_in),
    .trim_out     (trim_out),
    .match_pulse  (match_pulse),
    .samp_clk     (samp_clk),
    .cal_valid    (cal_valid),
    .cal_overflow (cal_overflow)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_osc);
    rst_n = 1'b0;
    ref_pulse = 1'b0;
    repeat (3) @(negedge clk_osc);
    rst_n = 1'b1;
    repeat (2) @(negedge clk_osc);
  endtask

  // High on exactly n rising edges; returns at the negedge where it is lowered
  task automatic send_pulse(input int n);
    @(negedge clk_osc);
    ref_pulse = 1'b1;
    repeat (n) @(negedge clk_osc);
    ref_pulse = 1'b0;
  endtask

  // Half-period measurement of samp_clk in cycles
  task automatic measure(output int hi, output int lo);
    int k;
    k = 0;
    while (samp_clk && k < 10000) begin @(negedge clk_osc); k++; end
    k = 0;
    while (!samp_clk && k < 10000) begin @(negedge clk_osc); k++; end
    hi = 0;
    while (samp_clk && hi < 10000) begin @(negedge clk_osc); hi++; end
    lo = 0;
    while (!samp_clk && lo < 10000) begin @(negedge clk_osc); lo++; end
  endtask

  task automatic count_match(input int window, output int cnt);
    cnt = 0;
    for (int i = 0; i < window; i++) begin
      @(negedge clk_osc);
      if (match_pulse) cnt++;
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_osc);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int sweep [15] = '{1, 2, 3, 4, 5, 7, 8, 13, 31, 64, 127, 256, 1000, 2047, 4094};
    int hi, lo, lat, mc;
    logic seen;

    // R2: reset state
    repeat (2) @(negedge clk_osc);
    chk(!match_pulse && !samp_clk && !cal_valid && !cal_overflow, "R2 in reset",
        {match_pulse, samp_clk, cal_valid, cal_overflow}, 0);
    rst_n = 1'b1;
    @(negedge clk_osc);
    chk(!match_pulse && !samp_clk && !cal_valid && !cal_overflow, "R2 after reset",
        {match_pulse, samp_clk, cal_valid, cal_overflow}, 0);

    // R1: trim pass-through
    for (int t = 0; t < 4; t++) begin
      trim_in = 2'(t);
      #1;
      chk(trim_out == 2'(t), "R1 trim", trim_out, t);
    end

    // R6: no output while idle and while the first pulse is being measured
    seen = 1'b0;
    fork
      send_pulse(40);
      for (int i = 0; i < 40; i++) begin
        @(negedge clk_osc);
        if (samp_clk || match_pulse || cal_valid) seen = 1'b1;
      end
    join
    chk(!seen, "R6 quiet before first calibration", seen, 0);

    // Sweep: R3 R4 R5 R10
    foreach (sweep[s]) begin
      int d;
      d = sweep[s];
      do_reset();
      send_pulse(d);
      lat = 0;
      do begin @(negedge clk_osc); lat++; end while (!samp_clk && lat < 10000);
      chk(lat == d + 3, $sformatf("R10 latency D=%0d", d), lat, d + 3);
      chk(cal_valid && !cal_overflow, $sformatf("R3 flags D=%0d", d),
          {cal_valid, cal_overflow}, 2);
      measure(hi, lo);
      chk(hi == d, $sformatf("R5 high time D=%0d", d), hi, d);
      chk(lo == d, $sformatf("R5 low time D=%0d", d), lo, d);
      count_match(2 * d, mc);
      chk(mc == 2, $sformatf("R4 match count D=%0d", d), mc, 2);
    end

    // R7: overflow before any calibration
    do_reset();
    send_pulse(5000);
    repeat (6) @(negedge clk_osc);
    chk(cal_overflow == 1'b1, "R7 overflow set uncal", cal_overflow, 1);
    chk(cal_valid == 1'b0, "R6 valid stays low after reject", cal_valid, 0);
    seen = 1'b0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk_osc);
      if (samp_clk || match_pulse) seen = 1'b1;
    end
    chk(!seen, "R6 clock idle after reject", seen, 0);

    // R7: overflow keeps previous width, then clears
    do_reset();
    send_pulse(6);
    repeat (10) @(negedge clk_osc);
    send_pulse(4095);
    repeat (6) @(negedge clk_osc);
    chk(cal_overflow == 1'b1, "R7 overflow set at 4095", cal_overflow, 1);
    chk(cal_valid == 1'b1, "R7 valid kept", cal_valid, 1);
    measure(hi, lo);
    chk(hi == 6 && lo == 6, "R7 period kept", hi + lo, 12);
    send_pulse(9);
    repeat (6) @(negedge clk_osc);
    chk(cal_overflow == 1'b0, "R7 overflow cleared", cal_overflow, 0);
    measure(hi, lo);
    chk(hi == 9 && lo == 9, "R8 new width after overflow", hi + lo, 18);

    // R9 then R8: old period during measurement, new period afterwards
    do_reset();
    send_pulse(10);
    repeat (10) @(negedge clk_osc);
    fork
      send_pulse(60);
      begin
        repeat (4) @(negedge clk_osc);
        measure(hi, lo);
      end
    join
    chk(hi == 10 && lo == 10, "R9 old period while measuring", hi + lo, 20);
    repeat (4) @(negedge clk_osc);
    chk(samp_clk == 1'b0, "R8 restart low", samp_clk, 0);
    measure(hi, lo);
    chk(hi == 60, "R8 replaced high time", hi, 60);
    chk(lo == 60, "R8 replaced low time", lo, 60);

    // R8: shorter replacement
    send_pulse(3);
    repeat (5) @(negedge clk_osc);
    measure(hi, lo);
    chk(hi == 3 && lo == 3, "R8 shorter replacement", hi + lo, 6);
    count_match(6, mc);
    chk(mc == 2, "R4 match count after replacement", mc, 2);

    finish_run();
  end

endmodule